// File: doc/BRIEF.md
# Memory Request to AXI4-Lite Master Bridge

This block lets a simple CPU-side memory port, which carries one request at a time, drive an AXI4-Lite slave. The requester raises a request valid together with an address, write data, a 4-bit byte-enable and a fetch flag, and keeps all of them steady until the bridge answers with a one-cycle ready. A zero byte-enable makes the request a read; any other legal value makes it a write.

A write puts address and data on the AW and W channels in the same cycle. Each channel lowers its valid on its own handshake, so the slave may take them in either order. Once both have been taken, the bridge waits for the B response. A read issues AR, then waits for R. The bridge pulses ready in the cycle the response handshake happens, and for reads it passes the R data straight through in that cycle. The fetch flag sets the instruction bit of the read protection field. Response codes are not reported back to the requester.

The controller has five states. IDLE waits for a request and goes to WR_SEND when the byte-enable is nonzero, or to RD_ADDR when it is zero. WR_SEND drives the write channels that are still pending and moves to WR_RESP once both AW and W are done. WR_RESP holds BREADY and returns to IDLE on BVALID. RD_ADDR drives ARVALID and moves to RD_RESP on ARREADY. RD_RESP holds RREADY and returns to IDLE on RVALID.

Top module: `memreq_axil_master`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, AWVALID, WVALID, ARVALID and the request ready are all low.
- R2: A request whose byte-enable is 4'b0000 is a read. ARADDR carries the request address, and the request never raises AWVALID or WVALID.
- R3: A request whose byte-enable is any of 1111, 1100, 0011, 1000, 0100, 0010 or 0001 is a write. AWVALID and WVALID rise in the same cycle, one cycle after the request is taken. AWADDR, WDATA and WSTRB equal the request address, data and byte-enable, and AWPROT is 3'b000. The request never raises ARVALID.
- R4: AWVALID and WVALID each stay high until their own handshake and are low in the following cycle. The other channel is unaffected, so the slave may accept them in either order or together.
- R5: BREADY rises only after both AW and W have been accepted, and it stays high until BVALID is seen.
- R6: The request ready is high for exactly one cycle per request, the cycle of the B or R handshake. In a read, the request read data equals RDATA in that cycle.
- R7: RREADY rises in the cycle after the AR handshake and stays high until RVALID is seen.
- R8: While BREADY or RREADY is high, AWVALID, WVALID and ARVALID are all low.
- R9: Once AWVALID, WVALID or ARVALID is high, it stays high with a steady payload until its ready arrives.
- R10: For reads, ARPROT is {fetch flag, 2'b00}. A fetch therefore sets bit 2, and a data read gives 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until req_ready |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write data |
| req_wstrb | input | DATA_W/8 | Byte enables; zero means read |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | DATA_W | Read data, valid with req_ready |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awprot | output | 3 | Write protection |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write strobes |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_arprot | output | 3 | Read protection |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | DATA_W | Read data |

## Verification
The AW handshake and the W handshake can happen on the same clock edge. In that case both done flags and the move to WR_RESP must occur together. The bench provokes this by giving the slave model zero wait on both channels, and by giving different waits in other runs so that each channel in turn finishes first. Each run is judged by the number of cycles each valid stays high, by BREADY staying high for exactly the response wait plus one, and by the captured payload.

// File: rtl/m2a_pkg.sv
package m2a_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WR_SEND = 3'd1,
        ST_WR_RESP = 3'd2,
        ST_RD_ADDR = 3'd3,
        ST_RD_RESP = 3'd4
    } m2a_state_e;

    localparam int unsigned PROT_W = 3;
    localparam logic [PROT_W-1:0] PROT_WRITE = 3'b000;

    // Bit 2 of the protection field marks an instruction access.
    function automatic logic [PROT_W-1:0] read_prot(input logic is_fetch);
        return {is_fetch, 2'b00};
    endfunction

endpackage

// File: rtl/m2a_hs_flag.sv
module m2a_hs_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic valid,
    input  logic ready,
    output logic done
);

    // Remembers that a channel handshake happened during the current write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (!arm) begin
            done <= 1'b0;
        end else if (valid && ready) begin
            done <= 1'b1;
        end
    end

endmodule

// File: rtl/m2a_fsm.sv
module m2a_fsm
    import m2a_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_is_write,
    input  logic aw_done,
    input  logic w_done,
    input  logic awready,
    input  logic wready,
    input  logic arready,
    input  logic bvalid,
    input  logic rvalid,
    output logic awvalid,
    output logic wvalid,
    output logic arvalid,
    output logic bready,
    output logic rready,
    output logic req_ready,
    output logic arm_write
);

    m2a_state_e state_q;
    m2a_state_e state_d;

    logic aw_fin;
    logic w_fin;

    assign aw_fin = aw_done || (awvalid && awready);
    assign w_fin  = w_done  || (wvalid  && wready);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = req_is_write ? ST_WR_SEND : ST_RD_ADDR;
                end
            end
            ST_WR_SEND: begin
                if (aw_fin && w_fin) begin
                    state_d = ST_WR_RESP;
                end
            end
            ST_WR_RESP: begin
                if (bvalid) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_ADDR: begin
                if (arready) begin
                    state_d = ST_RD_RESP;
                end
            end
            ST_RD_RESP: begin
                if (rvalid) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        awvalid   = 1'b0;
        wvalid    = 1'b0;
        arvalid   = 1'b0;
        bready    = 1'b0;
        rready    = 1'b0;
        req_ready = 1'b0;
        arm_write = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_WR_SEND: begin
                arm_write = 1'b1;
                awvalid   = !aw_done;
                wvalid    = !w_done;
            end
            ST_WR_RESP: begin
                bready    = 1'b1;
                req_ready = bvalid;
            end
            ST_RD_ADDR: begin
                arvalid = 1'b1;
            end
            ST_RD_RESP: begin
                rready    = 1'b1;
                req_ready = rvalid;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/memreq_axil_master.sv
module memreq_axil_master
    import m2a_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_fetch,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_wstrb,
    output logic                  req_ready,
    output logic [DATA_W-1:0]     req_rdata,
    output logic                  m_awvalid,
    input  logic                  m_awready,
    output logic [ADDR_W-1:0]     m_awaddr,
    output logic [2:0]            m_awprot,
    output logic                  m_wvalid,
    input  logic                  m_wready,
    output logic [DATA_W-1:0]     m_wdata,
    output logic [DATA_W/8-1:0]   m_wstrb,
    input  logic                  m_bvalid,
    output logic                  m_bready,
    output logic                  m_arvalid,
    input  logic                  m_arready,
    output logic [ADDR_W-1:0]     m_araddr,
    output logic [2:0]            m_arprot,
    input  logic                  m_rvalid,
    output logic                  m_rready,
    input  logic [DATA_W-1:0]     m_rdata
);

    localparam int unsigned STRB_W  = DATA_W / 8;
    localparam int unsigned N_WR_CH = 2;   // index 0: AW, index 1: W

    logic               arm_write;
    logic               is_write;
    logic [N_WR_CH-1:0] ch_valid;
    logic [N_WR_CH-1:0] ch_ready;
    logic [N_WR_CH-1:0] ch_done;

    assign is_write = (req_wstrb != {STRB_W{1'b0}});

    m2a_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_is_write (is_write),
        .aw_done      (ch_done[0]),
        .w_done       (ch_done[1]),
        .awready      (m_awready),
        .wready       (m_wready),
        .arready      (m_arready),
        .bvalid       (m_bvalid),
        .rvalid       (m_rvalid),
        .awvalid      (m_awvalid),
        .wvalid       (m_wvalid),
        .arvalid      (m_arvalid),
        .bready       (m_bready),
        .rready       (m_rready),
        .req_ready    (req_ready),
        .arm_write    (arm_write)
    );

    assign ch_valid = {m_wvalid, m_awvalid};
    assign ch_ready = {m_wready, m_awready};

    for (genvar g = 0; g < N_WR_CH; g++) begin : g_wr_flag
        m2a_hs_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (arm_write),
            .valid (ch_valid[g]),
            .ready (ch_ready[g]),
            .done  (ch_done[g])
        );
    end

    // Payload is a straight pass-through: the requester holds it steady.
    assign m_awaddr  = req_addr;
    assign m_awprot  = PROT_WRITE;
    assign m_wdata   = req_wdata;
    assign m_wstrb   = req_wstrb;
    assign m_araddr  = req_addr;
    assign m_arprot  = read_prot(req_fetch);
    assign req_rdata = m_rdata;

endmodule

// File: rtl/m2a_checker.sv
module m2a_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_fetch,
    input logic [DATA_W/8-1:0] req_wstrb,
    input logic                req_ready,
    input logic                m_awvalid,
    input logic                m_awready,
    input logic [ADDR_W-1:0]   m_awaddr,
    input logic                m_wvalid,
    input logic                m_wready,
    input logic [DATA_W-1:0]   m_wdata,
    input logic                m_bvalid,
    input logic                m_bready,
    input logic                m_arvalid,
    input logic                m_arready,
    input logic [ADDR_W-1:0]   m_araddr,
    input logic [2:0]          m_arprot,
    input logic                m_rvalid,
    input logic                m_rready
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!m_awvalid && !m_wvalid && !m_arvalid && !req_ready));

    assert_read_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> (req_wstrb == '0));

    assert_write_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (req_wstrb != '0));

    assert_write_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> $rose(m_wvalid));

    assert_aw_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && m_awready) |=> !m_awvalid);

    assert_w_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && m_wready) |=> !m_wvalid);

    assert_bready_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bready && !m_bvalid) |=> m_bready);

    assert_ready_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((m_bvalid && m_bready) || (m_rvalid && m_rready)));

    assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_rready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rready && !m_rvalid) |=> m_rready);

    assert_rready_after_ar_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && m_arready) |=> m_rready);

    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bready || m_rready) |-> !(m_awvalid || m_wvalid || m_arvalid));

    assert_aw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    assert_w_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));

    assert_ar_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

    assert_fetch_prot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> (m_arprot[2] == req_fetch));

endmodule

bind memreq_axil_master m2a_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fetch (req_fetch),
    .req_wstrb (req_wstrb),
    .req_ready (req_ready),
    .m_awvalid (m_awvalid),
    .m_awready (m_awready),
    .m_awaddr  (m_awaddr),
    .m_wvalid  (m_wvalid),
    .m_wready  (m_wready),
    .m_wdata   (m_wdata),
    .m_bvalid  (m_bvalid),
    .m_bready  (m_bready),
    .m_arvalid (m_arvalid),
    .m_arready (m_arready),
    .m_araddr  (m_araddr),
    .m_arprot  (m_arprot),
    .m_rvalid  (m_rvalid),
    .m_rready  (m_rready)
);

// File: tb/sim_memreq_axil_master.sv
module sim_memreq_axil_master;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst_n;
    logic          req_valid, req_fetch, req_ready;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata, req_rdata;
    logic [SW-1:0] req_wstrb;
    logic          m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
    logic          m_arvalid, m_arready, m_rvalid, m_rready;
    logic [AW-1:0] m_awaddr, m_araddr;
    logic [2:0]    m_awprot, m_arprot;
    logic [DW-1:0] m_wdata, m_rdata;
    logic [SW-1:0] m_wstrb;

    memreq_axil_master #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_fetch(req_fetch), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_wstrb(req_wstrb),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awprot(m_awprot),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr), .m_arprot(m_arprot),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          wr;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [2:0]  prot;
    } exp_t;
    exp_t expq[$];

    // slave model controls and observations
    int dly_aw, dly_w, dly_b, dly_ar, dly_r;
    int wt_aw, wt_w, wt_b, wt_ar, wt_r;
    int hi_aw, hi_w, hi_b, hi_ar, hi_r;
    int rdy_seen;
    logic [31:0] cap_awaddr, cap_wdata, cap_araddr;
    logic [3:0]  cap_wstrb;
    logic [2:0]  cap_awprot, cap_arprot;
    bit pair_err, ovl_err;
    logic prev_aw, prev_w;

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        m_awready = 0; m_wready = 0; m_bvalid = 0;
        m_arready = 0; m_rvalid = 0; m_rdata = '0;
        wt_aw = 0; wt_w = 0; wt_b = 0; wt_ar = 0; wt_r = 0;
        pair_err = 0; ovl_err = 0; prev_aw = 0; prev_w = 0;
    end

    // AXI4-Lite slave model, acting 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if ((m_awvalid && !prev_aw) != (m_wvalid && !prev_w)) pair_err = 1;
            if ((m_bready || m_rready) && (m_awvalid || m_wvalid || m_arvalid)) ovl_err = 1;
        end
        prev_aw = m_awvalid;
        prev_w  = m_wvalid;

        if (m_awvalid) begin
            hi_aw++;
            if (wt_aw >= dly_aw) begin
                m_awready = 1; cap_awaddr = m_awaddr; cap_awprot = m_awprot;
            end else begin
                m_awready = 0; wt_aw++;
            end
        end else begin
            m_awready = 0; wt_aw = 0;
        end

        if (m_wvalid) begin
            hi_w++;
            if (wt_w >= dly_w) begin
                m_wready = 1; cap_wdata = m_wdata; cap_wstrb = m_wstrb;
            end else begin
                m_wready = 0; wt_w++;
            end
        end else begin
            m_wready = 0; wt_w = 0;
        end

        if (m_bready) begin
            hi_b++;
            if (wt_b >= dly_b) m_bvalid = 1;
            else begin m_bvalid = 0; wt_b++; end
        end else begin
            m_bvalid = 0; wt_b = 0;
        end

        if (m_arvalid) begin
            hi_ar++;
            if (wt_ar >= dly_ar) begin
                m_arready = 1; cap_araddr = m_araddr; cap_arprot = m_arprot;
            end else begin
                m_arready = 0; wt_ar++;
            end
        end else begin
            m_arready = 0; wt_ar = 0;
        end

        if (m_rready) begin
            hi_r++;
            if (wt_r >= dly_r) begin
                m_rvalid = 1; m_rdata = mem_val(cap_araddr);
            end else begin
                m_rvalid = 0; wt_r++;
            end
        end else begin
            m_rvalid = 0; wt_r = 0;
        end
    end

    // Monitor: pops the scoreboard on each completion pulse
    always @(negedge clk) begin
        if (rst_n && req_ready) begin
            rdy_seen++;
            if (req_valid) begin
                if (expq.size() == 0) begin
                    chk("R6 ready with no pending request", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (e.wr) begin
                        chk("R3 AWADDR", cap_awaddr, e.addr);
                        chk("R3 WDATA", cap_wdata, e.data);
                        chk("R3 WSTRB", {28'd0, cap_wstrb}, {28'd0, e.strb});
                        chk("R3 AWPROT", {29'd0, cap_awprot}, {29'd0, e.prot});
                    end else begin
                        chk("R2 ARADDR", cap_araddr, e.addr);
                        chk("R10 ARPROT", {29'd0, cap_arprot}, {29'd0, e.prot});
                        chk("R6 read data", req_rdata, e.data);
                    end
                end
            end
        end
    end

    task automatic txn(input logic [31:0] addr, input logic [31:0] data, input logic [3:0] strb,
                       input logic fetch, input int daw, input int dw, input int db,
                       input int dar, input int dr);
        exp_t e;
        bit wr;
        wr = (strb != 4'b0000);
        @(posedge clk); #1;
        dly_aw = daw; dly_w = dw; dly_b = db; dly_ar = dar; dly_r = dr;
        hi_aw = 0; hi_w = 0; hi_b = 0; hi_ar = 0; hi_r = 0; rdy_seen = 0;
        e.wr = wr; e.addr = addr; e.strb = strb;
        e.data = wr ? data : mem_val(addr);
        e.prot = wr ? 3'b000 : {fetch, 2'b00};
        expq.push_back(e);
        req_addr = addr; req_wdata = data; req_wstrb = strb; req_fetch = fetch;
        req_valid = 1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 0;
        repeat (2) @(negedge clk);
        chk("R6 one ready pulse", rdy_seen, 1);
        if (wr) begin
            chk("R4 AWVALID cycles", hi_aw, daw + 1);
            chk("R4 WVALID cycles", hi_w, dw + 1);
            chk("R5 BREADY cycles", hi_b, db + 1);
            chk("R3 no ARVALID on write", hi_ar + hi_r, 0);
        end else begin
            chk("R9 ARVALID cycles", hi_ar, dar + 1);
            chk("R7 RREADY cycles", hi_r, dr + 1);
            chk("R2 no write channel on read", hi_aw + hi_w + hi_b, 0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_fetch = 0;
        req_addr = '0; req_wdata = '0; req_wstrb = '0;
        dly_aw = 0; dly_w = 0; dly_b = 0; dly_ar = 0; dly_r = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valids low in reset", {29'd0, m_awvalid, m_wvalid, m_arvalid}, 32'd0);
        chk("R1 ready low in reset", {31'd0, req_ready}, 32'd0);
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk("R1 valids low after reset", {29'd0, m_awvalid, m_wvalid, m_arvalid}, 32'd0);

        // R3/R4: simultaneous AW and W acceptance
        txn(32'h0000_1000, 32'hDEAD_BEEF, 4'b1111, 0, 0, 0, 0, 0, 0);
        // R4: W accepted first, AW later
        txn(32'h0000_2004, 32'h1234_5678, 4'b0011, 0, 3, 0, 1, 0, 0);
        // R4: AW accepted first, W later
        txn(32'h0000_3008, 32'hCAFE_F00D, 4'b1100, 0, 0, 4, 2, 0, 0);
        txn(32'h0000_400C, 32'hA5A5_5A5A, 4'b1000, 1, 2, 2, 0, 0, 0);
        txn(32'h0000_5010, 32'h0F0F_F0F0, 4'b0100, 0, 1, 0, 3, 0, 0);
        txn(32'h0000_6014, 32'h1111_2222, 4'b0010, 0, 0, 1, 0, 0, 0);
        txn(32'h0000_7018, 32'h3333_4444, 4'b0001, 0, 5, 5, 5, 0, 0);
        // R2/R10: reads, fetch and data
        txn(32'h0000_8000, 32'h0, 4'b0000, 1, 0, 0, 0, 0, 0);
        txn(32'h0000_9004, 32'h0, 4'b0000, 0, 0, 0, 0, 3, 2);
        txn(32'h0000_A008, 32'h0, 4'b0000, 1, 0, 0, 0, 0, 5);
        // mixed sequence
        txn(32'hFFFF_FFFC, 32'h8765_4321, 4'b1111, 0, 0, 0, 0, 0, 0);
        txn(32'hFFFF_FFFC, 32'h0, 4'b0000, 0, 0, 0, 0, 1, 0);

        chk("R3 AWVALID and WVALID rose together", {31'd0, pair_err}, 32'd0);
        chk("R8 no request while response pending", {31'd0, ovl_err}, 32'd0);
        chk("R6 scoreboard drained", expq.size(), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule